// File: doc/BRIEF.md
# MDIO Management Frame Monitor

This block is a passive observer for the two-wire management bus between an Ethernet MAC and its PHYs. It oversamples the management clock and data lines with a faster system clock, finds each rising edge of the management clock, and takes one data bit per edge. From that bit stream it recovers both the older (Clause 22) and the extended (Clause 45) frame formats. It never drives either line.

When a read or write frame finishes, the monitor raises `txn_valid` for exactly one system clock. In that cycle the record ports carry the frame format, the transfer direction, both 5-bit address fields, the 16-bit data word, the extended-register address the monitor is tracking, and a set of error flags. Malformed preambles, opcodes and turnarounds are flagged, but the frame is still decoded and reported. Extended-format address frames load the tracked register address and produce no record. Read-with-increment frames advance that address after they are reported.

Top module: `mdio_mon`

## Requirements
- R1: MDC and MDIO each pass through a two-stage synchroniser. One MDIO bit is taken on each synchronised rising edge of MDC. Each reported frame raises `txn_valid` for exactly one system clock, and `txn_valid` is 0 after reset.
- R2: A preamble of 32 or more ones followed by a zero is accepted without error. Ones beyond 32 count as bus idle and raise no flag.
- R3: A zero that follows 17 to 31 ones sets `err_short_pre` on that frame and is taken as the first start bit.
- R4: A zero that follows 16 or fewer ones puts the monitor into an illegal-bus state. It stays there while MDIO is 0. The next 1 leaves the state and counts as the first preamble one. The next reported record then has `err_illegal` = 1.
- R5: Start bits 0,1 select Clause 22 (`txn_c45` = 0). Start bits 0,0 select Clause 45 (`txn_c45` = 1).
- R6: In Clause 22, opcode bits 1,0 are a read and 0,1 are a write. Opcodes 0,0 and 1,1 set `err_opcode`, and `txn_read` then equals the first opcode bit.
- R7: In Clause 45, opcode 0,0 is an address frame, which produces no `txn_valid`. Opcode 0,1 is a write, and opcodes 1,0 and 1,1 are reads. `err_opcode` is never set in Clause 45.
- R8: After the opcode come a 5-bit port address (`txn_port`), a 5-bit device/register address (`txn_dev`), two turnaround bits and 16 data bits (`txn_data`). Every field is sent MSB first.
- R9: The turnaround is checked. `err_ta[0]` is set when the first turnaround bit is 0 in a frame whose first opcode bit is 0. `err_ta[1]` is set when the second turnaround bit is 1, in any frame.
- R10: `txn_addr` and `txn_addr_known` give the tracked Clause 45 address as it stood before the reported frame. The address is unknown after reset. A Clause 45 address frame loads its data word and marks the address known.
- R11: A Clause 45 read-with-increment frame (opcode 1,0) adds 1 to the tracked address, modulo 2^16, after it is reported, but only when the address is known. A read with opcode 1,1 leaves the address unchanged.
- R12: After every frame, the monitor goes back to preamble hunting with the ones count at zero and all error flags cleared, so flags never carry into the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than MDC |
| rst | input | 1 | Synchronous active-high reset |
| mdc_in | input | 1 | Management clock line (asynchronous) |
| mdio_in | input | 1 | Management data line (asynchronous) |
| txn_valid | output | 1 | One-cycle pulse: a read/write record is present |
| txn_c45 | output | 1 | 1 = Clause 45 frame, 0 = Clause 22 |
| txn_read | output | 1 | 1 = read, 0 = write |
| txn_port | output | 5 | Port / PHY address field |
| txn_dev | output | 5 | Device / register address field |
| txn_data | output | 16 | Data word |
| txn_addr | output | 16 | Tracked Clause 45 register address before this frame |
| txn_addr_known | output | 1 | Tracked address has been loaded since reset |
| err_short_pre | output | 1 | Preamble had 17 to 31 ones |
| err_illegal | output | 1 | Illegal bus state was seen before this frame |
| err_opcode | output | 1 | Clause 22 opcode 0,0 or 1,1 |
| err_ta | output | 2 | Bit 0: first turnaround bit wrong; bit 1: second turnaround bit wrong |

## Verification
The hardest behaviour to reach is the interaction of the tracked address with frame history. A read-with-increment must leave an unknown address unknown, and a known address must wrap from FFFF to 0000. Neither can be seen from a single frame. The stimulus therefore issues read-with-increment frames before any address frame, then loads FFFE and issues three back-to-back increments. The illegal-bus path is reached by sending a burst of zeros after a short run of ones, including right after a completed frame when the ones count is zero. The bench then checks that the flag lands on the following record and on no later one.

// File: rtl/mdio_mon_pkg.sv
package mdio_mon_pkg;

    localparam int PORT_W     = 5;
    localparam int DEV_W      = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_FULL   = 32;
    localparam int PRE_MIN    = 17;
    localparam int ONES_W     = $clog2(PRE_FULL) + 1;
    localparam int CNT_W      = $clog2(DATA_W);

    typedef enum logic [2:0] {
        PH_HUNT,
        PH_ILLEGAL,
        PH_START,
        PH_OP,
        PH_PORT,
        PH_DEV,
        PH_TA,
        PH_DATA
    } phase_t;

    typedef struct packed {
        logic              c45;
        logic [1:0]        op;
        logic [PORT_W-1:0] port;
        logic [DEV_W-1:0]  dev;
        logic [DATA_W-1:0] data;
        logic              short_pre;
        logic              illegal;
        logic              op_bad;
        logic [1:0]        ta_bad;
    } frame_t;

    // Both formats: a first opcode bit of 1 means a read.
    function automatic logic op_is_read(input logic [1:0] op);
        return op[1];
    endfunction

    // First turnaround bit must be 1 for frames whose first opcode bit is 0.
    function automatic logic ta_first_required(input logic [1:0] op);
        return !op[1];
    endfunction

    function automatic logic is_addr_frame(input frame_t f);
        return f.c45 && (f.op == 2'b00);
    endfunction

    function automatic logic is_read_inc(input frame_t f);
        return f.c45 && (f.op == 2'b10);
    endfunction

endpackage

// File: rtl/mdio_mon_sampler.sv
module mdio_mon_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc_raw,
    input  logic mdio_raw,
    output logic bit_strobe,
    output logic bit_val
);
    logic [STAGES-1:0] mdc_sync;
    logic [STAGES-1:0] mdio_sync;
    logic              mdc_prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    mdc_sync  <= '1;
                    mdio_sync <= '1;
                end else begin
                    mdc_sync  <= mdc_raw;
                    mdio_sync <= mdio_raw;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    mdc_sync  <= '1;
                    mdio_sync <= '1;
                end else begin
                    mdc_sync  <= {mdc_sync[STAGES-2:0], mdc_raw};
                    mdio_sync <= {mdio_sync[STAGES-2:0], mdio_raw};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) mdc_prev <= 1'b1;
        else     mdc_prev <= mdc_sync[STAGES-1];
    end

    assign bit_strobe = mdc_sync[STAGES-1] & ~mdc_prev;
    assign bit_val    = mdio_sync[STAGES-1];

endmodule

// File: rtl/mdio_mon_framer.sv
module mdio_mon_framer
    import mdio_mon_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_strobe,
    input  logic   bit_val,
    output logic   frame_done,
    output frame_t frame_rec
);
    phase_t             phase;
    frame_t             cur;
    logic [CNT_W-1:0]   cnt;
    logic [ONES_W-1:0]  ones;

    localparam logic [ONES_W-1:0] ONES_MAX  = '1;
    localparam logic [ONES_W-1:0] ONES_FULL = ONES_W'(PRE_FULL);
    localparam logic [ONES_W-1:0] ONES_MIN  = ONES_W'(PRE_MIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_HUNT;
            cur        <= '0;
            cnt        <= '0;
            ones       <= '0;
            frame_done <= 1'b0;
            frame_rec  <= '0;
        end else begin
            frame_done <= 1'b0;
            if (bit_strobe) begin
                unique case (phase)
                    PH_HUNT: begin
                        if (bit_val) begin
                            if (ones != ONES_MAX) ones <= ones + 1'b1;
                        end else if (ones >= ONES_MIN) begin
                            cur.short_pre <= (ones < ONES_FULL);
                            phase         <= PH_START;
                        end else begin
                            phase <= PH_ILLEGAL;
                        end
                    end
                    PH_ILLEGAL: begin
                        if (bit_val) begin
                            cur.illegal <= 1'b1;
                            ones        <= ONES_W'(1);
                            phase       <= PH_HUNT;
                        end
                    end
                    PH_START: begin
                        cur.c45 <= !bit_val;
                        cnt     <= '0;
                        phase   <= PH_OP;
                    end
                    PH_OP: begin
                        if (cnt == '0) begin
                            cur.op[1] <= bit_val;
                            cnt       <= CNT_W'(1);
                        end else begin
                            cur.op[0]  <= bit_val;
                            cur.op_bad <= !cur.c45 && (bit_val == cur.op[1]);
                            cnt        <= '0;
                            phase      <= PH_PORT;
                        end
                    end
                    PH_PORT: begin
                        cur.port <= {cur.port[PORT_W-2:0], bit_val};
                        if (cnt == CNT_W'(PORT_W - 1)) begin
                            cnt   <= '0;
                            phase <= PH_DEV;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_DEV: begin
                        cur.dev <= {cur.dev[DEV_W-2:0], bit_val};
                        if (cnt == CNT_W'(DEV_W - 1)) begin
                            cnt   <= '0;
                            phase <= PH_TA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_TA: begin
                        if (cnt == '0) begin
                            cur.ta_bad[0] <= ta_first_required(cur.op) && !bit_val;
                            cnt           <= CNT_W'(1);
                        end else begin
                            cur.ta_bad[1] <= bit_val;
                            cnt           <= '0;
                            phase         <= PH_DATA;
                        end
                    end
                    PH_DATA: begin
                        if (cnt == CNT_W'(DATA_W - 1)) begin
                            frame_rec      <= cur;
                            frame_rec.data <= {cur.data[DATA_W-2:0], bit_val};
                            frame_done     <= 1'b1;
                            cur            <= '0;
                            cnt            <= '0;
                            ones           <= '0;
                            phase          <= PH_HUNT;
                        end else begin
                            cur.data <= {cur.data[DATA_W-2:0], bit_val};
                            cnt      <= cnt + 1'b1;
                        end
                    end
                    default: phase <= PH_HUNT;
                endcase
            end
        end
    end

endmodule

// File: rtl/mdio_mon_tracker.sv
module mdio_mon_tracker
    import mdio_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done,
    input  frame_t            frame_rec,
    output logic [DATA_W-1:0] trk_addr,
    output logic              trk_known
);
    always_ff @(posedge clk) begin
        if (rst) begin
            trk_addr  <= '0;
            trk_known <= 1'b0;
        end else if (frame_done) begin
            if (is_addr_frame(frame_rec)) begin
                trk_addr  <= frame_rec.data;
                trk_known <= 1'b1;
            end else if (is_read_inc(frame_rec) && trk_known) begin
                trk_addr <= trk_addr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mdio_mon.sv
module mdio_mon
    import mdio_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdc_in,
    input  logic              mdio_in,
    output logic              txn_valid,
    output logic              txn_c45,
    output logic              txn_read,
    output logic [PORT_W-1:0] txn_port,
    output logic [DEV_W-1:0]  txn_dev,
    output logic [DATA_W-1:0] txn_data,
    output logic [DATA_W-1:0] txn_addr,
    output logic              txn_addr_known,
    output logic              err_short_pre,
    output logic              err_illegal,
    output logic              err_opcode,
    output logic [1:0]        err_ta
);
    logic              bit_strobe;
    logic              bit_val;
    logic              frame_done;
    frame_t            rec;
    logic [DATA_W-1:0] trk_addr;
    logic              trk_known;

    mdio_mon_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk        (clk),
        .rst        (rst),
        .mdc_raw    (mdc_in),
        .mdio_raw   (mdio_in),
        .bit_strobe (bit_strobe),
        .bit_val    (bit_val)
    );

    mdio_mon_framer u_framer (
        .clk        (clk),
        .rst        (rst),
        .bit_strobe (bit_strobe),
        .bit_val    (bit_val),
        .frame_done (frame_done),
        .frame_rec  (rec)
    );

    mdio_mon_tracker u_tracker (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .frame_rec  (rec),
        .trk_addr   (trk_addr),
        .trk_known  (trk_known)
    );

    assign txn_valid      = frame_done && !is_addr_frame(rec);
    assign txn_c45        = rec.c45;
    assign txn_read       = op_is_read(rec.op);
    assign txn_port       = rec.port;
    assign txn_dev        = rec.dev;
    assign txn_data       = rec.data;
    assign txn_addr       = trk_addr;
    assign txn_addr_known = trk_known;
    assign err_short_pre  = rec.short_pre;
    assign err_illegal    = rec.illegal;
    assign err_opcode     = rec.op_bad;
    assign err_ta         = rec.ta_bad;

endmodule

// File: rtl/mdio_mon_checker.sv
module mdio_mon_checker
    import mdio_mon_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              txn_valid,
    input logic              frame_done,
    input frame_t            rec,
    input logic [DATA_W-1:0] trk_addr,
    input logic              trk_known
);
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        txn_valid |=> !txn_valid);

    a_r7_addr_silent: assert property (@(posedge clk) disable iff (rst)
        (frame_done && rec.c45 && rec.op == 2'b00) |-> !txn_valid);

    a_r10_addr_load: assert property (@(posedge clk) disable iff (rst)
        (frame_done && rec.c45 && rec.op == 2'b00)
        |=> (trk_known && trk_addr == $past(rec.data)));

    a_r10_known_sticks: assert property (@(posedge clk) disable iff (rst)
        trk_known |=> trk_known);

    a_r11_post_inc: assert property (@(posedge clk) disable iff (rst)
        (frame_done && rec.c45 && rec.op == 2'b10 && trk_known)
        |=> (trk_addr == $past(trk_addr) + 16'd1));

    a_r11_unknown_holds: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !trk_known && !(rec.c45 && rec.op == 2'b00))
        |=> !trk_known);

endmodule

bind mdio_mon mdio_mon_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .txn_valid  (txn_valid),
    .frame_done (frame_done),
    .rec        (rec),
    .trk_addr   (trk_addr),
    .trk_known  (trk_known)
);

// File: tb/mdio_mon_test.sv
module mdio_mon_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mdc = 1'b0;
    logic        mdio = 1'b1;
    logic        txn_valid, txn_c45, txn_read, txn_addr_known;
    logic        err_short_pre, err_illegal, err_opcode;
    logic [1:0]  err_ta;
    logic [4:0]  txn_port, txn_dev;
    logic [15:0] txn_data, txn_addr;

    int checks = 0;
    int fails  = 0;
    logic [49:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] m_addr = 16'h0;
    bit          m_known = 1'b0;
    bit          m_illegal = 1'b0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    mdio_mon uut (
        .clk(clk), .rst(rst), .mdc_in(mdc), .mdio_in(mdio),
        .txn_valid(txn_valid), .txn_c45(txn_c45), .txn_read(txn_read),
        .txn_port(txn_port), .txn_dev(txn_dev), .txn_data(txn_data),
        .txn_addr(txn_addr), .txn_addr_known(txn_addr_known),
        .err_short_pre(err_short_pre), .err_illegal(err_illegal),
        .err_opcode(err_opcode), .err_ta(err_ta)
    );

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (!rst && txn_valid) begin
            logic [49:0] act;
            act = {txn_c45, txn_read, txn_port, txn_dev, txn_data, txn_addr,
                   txn_addr_known, err_short_pre, err_illegal, err_opcode, err_ta};
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected record act=%h exp=none", act);
            end else begin
                logic [49:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (act !== e) begin
                    fails++;
                    $display("FAIL %s record act=%h exp=%h", t, act, e);
                end
            end
        end
    end

    task automatic send_bit(input bit b);
        mdio = b;
        repeat (4) @(posedge clk);
        mdc = 1'b1;
        repeat (4) @(posedge clk);
        mdc = 1'b0;
    endtask

    task automatic send_frame(input int pre, input bit c45, input logic [1:0] op,
                              input logic [4:0] port, input logic [4:0] dev,
                              input logic [1:0] ta, input logic [15:0] data,
                              input string tag);
        bit rd, opbad, short;
        logic [1:0] tab;
        rd    = op[1];
        opbad = !c45 && (op[1] == op[0]);
        short = (pre < 32);
        tab   = {ta[0], (!op[1] && !ta[1])};
        if (!(c45 && op == 2'b00)) begin
            exp_q.push_back({c45, rd, port, dev, data, m_addr, m_known,
                             short, m_illegal, opbad, tab});
            tag_q.push_back(tag);
        end
        m_illegal = 1'b0;
        if (c45 && op == 2'b00) begin
            m_addr  = data;
            m_known = 1'b1;
        end else if (c45 && op == 2'b10 && m_known) begin
            m_addr = m_addr + 16'd1;
        end
        for (int i = 0; i < pre; i++) send_bit(1'b1);
        send_bit(1'b0);
        send_bit(!c45);
        send_bit(op[1]); send_bit(op[0]);
        for (int i = 4; i >= 0; i--) send_bit(port[i]);
        for (int i = 4; i >= 0; i--) send_bit(dev[i]);
        send_bit(ta[1]); send_bit(ta[0]);
        for (int i = 15; i >= 0; i--) send_bit(data[i]);
    endtask

    task automatic send_garbage(input int n1, input int n0);
        for (int i = 0; i < n1; i++) send_bit(1'b1);
        for (int i = 0; i < n0; i++) send_bit(1'b0);
        m_illegal = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        rst = 1'b0;
        // R1: reset state, no record while the bus is quiet
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            checks++;
            if (txn_valid !== 1'b0) begin
                fails++;
                $display("FAIL R1 reset valid act=%b exp=0", txn_valid);
            end
        end
        // R11/R10: read-increment with unknown address keeps it unknown
        send_frame(32, 1, 2'b10, 5'd3, 5'd1, 2'b10, 16'h1234, "R11");
        send_frame(32, 1, 2'b10, 5'd3, 5'd1, 2'b10, 16'h5678, "R10");
        // R5/R8: Clause 22 read
        send_frame(32, 0, 2'b10, 5'h15, 5'h0A, 2'b10, 16'hA5C3, "R8");
        // R2: long idle before a write
        send_frame(50, 0, 2'b01, 5'h01, 5'h1F, 2'b10, 16'h8001, "R2");
        // R3: short preamble, then R12 flags cleared
        send_frame(20, 0, 2'b01, 5'h10, 5'h02, 2'b10, 16'h0F0F, "R3");
        send_frame(32, 0, 2'b10, 5'h04, 5'h05, 2'b10, 16'hF0F0, "R12");
        // R6: invalid Clause 22 opcodes
        send_frame(32, 0, 2'b11, 5'h07, 5'h08, 2'b10, 16'h1111, "R6");
        send_frame(32, 0, 2'b00, 5'h09, 5'h0B, 2'b00, 16'h2222, "R6");
        // R9: turnaround faults
        send_frame(32, 0, 2'b01, 5'h0C, 5'h0D, 2'b01, 16'h3333, "R9");
        send_frame(32, 0, 2'b10, 5'h0E, 5'h11, 2'b00, 16'h4444, "R9");
        send_frame(32, 0, 2'b10, 5'h12, 5'h13, 2'b11, 16'h5555, "R9");
        // R7/R10: address frame then write
        send_frame(32, 1, 2'b00, 5'h02, 5'h03, 2'b10, 16'hFFFE, "R7");
        send_frame(32, 1, 2'b01, 5'h02, 5'h03, 2'b10, 16'hBEEF, "R7");
        // R11: increments and wrap
        send_frame(32, 1, 2'b10, 5'h02, 5'h03, 2'b10, 16'h0001, "R11");
        send_frame(32, 1, 2'b10, 5'h02, 5'h03, 2'b10, 16'h0002, "R11");
        send_frame(32, 1, 2'b10, 5'h02, 5'h03, 2'b10, 16'h0003, "R11");
        send_frame(32, 1, 2'b11, 5'h02, 5'h03, 2'b10, 16'h0004, "R11");
        send_frame(32, 1, 2'b11, 5'h02, 5'h03, 2'b10, 16'h0005, "R5");
        // R4: illegal bus state, then clean frame clears flag (R12)
        send_garbage(5, 7);
        send_frame(32, 0, 2'b01, 5'h1E, 5'h06, 2'b10, 16'h7777, "R4");
        send_garbage(0, 3);
        send_frame(32, 1, 2'b01, 5'h1D, 5'h07, 2'b10, 16'h9999, "R4");
        send_frame(32, 0, 2'b10, 5'h1C, 5'h08, 2'b10, 16'hAAAA, "R12");
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        repeat (20) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1 missing records act=%0d exp=0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule